// File: doc/BRIEF.md
# Asynchronous serial receiver with read-sequenced status clearing

This block takes an asynchronous serial line and assembles characters from it. A character is a low start bit, then 8 or 9 data bits sent least significant bit first, then a high stop bit. The block samples the line on an external tick that runs at 16 times the bit rate. Each completed character is placed in a receive data register and raises a "full" flag. The block also keeps four other flags: overrun, noise, framing error and idle line. A receive interrupt request is formed from these flags.

Software clears the flags with two steps. First it reads the status, which captures the flags that are set at that moment. Then it reads the data, which clears only the captured flags. A character that completes between the two reads cancels the pending clear, so software cannot lose a flag it never saw.

Top module: `sci_rx_core`

## Requirements
- R1: After reset, every status flag output, `rx_data`, `rx_bit8` and `rx_irq` are 0.
- R2: A frame is a low start bit, then the data bits LSB first, then the stop bit. When the stop bit is decided, `rx_data` takes the data bits and `rx_full` goes to 1.
- R3: If `rx_full` is still 1 when a further character completes, `overrun` goes to 1. `rx_data` takes the newer character.
- R4: A `stat_rd` pulse records which of the five flags are set. A later `data_rd` pulse clears exactly those recorded flags and no others. A flag that became set after the `stat_rd` survives.
- R5: A `data_rd` pulse with no recorded `stat_rd` leaves every flag unchanged.
- R6: A character that completes after `stat_rd` and before `data_rd` discards the record, so that `data_rd` clears nothing.
- R7: While `rx_en` is 0, no character is received and the flags are not set by line activity.
- R8: `rx_irq` is 1 exactly when `rie` is 1 and at least one of `rx_full` or `overrun` is 1.
- R9: Each bit is sampled on ticks 7, 8 and 9 counted from the start edge within its 16-tick cell, and the value is decided by a 2-of-3 vote. If any bit of the frame had three samples that did not agree, `noise` is set. The voted data is still delivered.
- R10: If the stop bit is voted 0, `frame_err` is set.
- R11: After a character has been received, if the line stays high for one full frame length of ticks (10×16 ticks, or 11×16 when `nine_bit` is 1), `line_idle` is set. This happens once per received character.
- R12: When `nine_bit` is 1, the frame carries 9 data bits. The ninth bit appears on `rx_bit8` and the low eight bits appear on `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial receive line, idles high |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_en | input | 1 | Receiver enable |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 data bits |
| rie | input | 1 | Receive interrupt enable |
| stat_rd | input | 1 | Status read strobe |
| data_rd | input | 1 | Data read strobe |
| rx_data | output | 8 | Last received character |
| rx_bit8 | output | 1 | Ninth data bit of the last character |
| rx_full | output | 1 | Receive data register full |
| line_idle | output | 1 | Idle line seen |
| overrun | output | 1 | Character lost to overrun |
| noise | output | 1 | Sample disagreement seen |
| frame_err | output | 1 | Stop bit received low |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A wrong phase or bit counter shows at the ports only when a frame completes. The effect is a shifted `rx_data` value or a spurious `frame_err`, so every frame check is made a few clocks after the last stop-bit tick. A stale or lost status record shows at the next `data_rd`: either flags survive that should clear, or flags clear that should survive. The bench therefore places a character, or an idle event, between the two reads and checks the flags on the following cycle. A broken idle counter shows only a full frame time after the last character, so the bench checks both just below and just above that threshold.

// File: rtl/sci_rx_core.sv
module sci_rx_core #(
  parameter int OS = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic          tick16,
  input  logic          rx_en,
  input  logic          nine_bit,
  input  logic          rie,
  input  logic          stat_rd,
  input  logic          data_rd,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit8,
  output logic          rx_full,
  output logic          line_idle,
  output logic          overrun,
  output logic          noise,
  output logic          frame_err,
  output logic          rx_irq
);
  localparam int PW = $clog2(OS);
  localparam int BW = $clog2(DW + 3);
  localparam int IW = $clog2((DW + 3) * OS + 1);
  localparam logic [PW-1:0] S0   = PW'(OS / 2 - 1);
  localparam logic [PW-1:0] S1   = PW'(OS / 2);
  localparam logic [PW-1:0] S2   = PW'(OS / 2 + 1);
  localparam logic [PW-1:0] LAST = PW'(OS - 1);
  localparam int F_FULL = 4, F_IDLE = 3, F_OVR = 2, F_NSE = 1, F_FRM = 0;

  logic          rx_m, rx_s, prev;
  logic          busy, armed, nf_acc, idle_pulse;
  logic [PW-1:0] phase;
  logic [BW-1:0] bitn;
  logic [2:0]    smp;
  logic [DW:0]   shreg;
  logic [IW-1:0] icnt;
  logic [4:0]    flg, cap, flg_clr;
  logic          cap_v;

  wire vote      = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
  wire disagree  = ~((smp[0] == smp[1]) && (smp[1] == smp[2]));
  wire is_start  = (bitn == '0);
  wire [BW-1:0] stop_idx = nine_bit ? BW'(DW + 2) : BW'(DW + 1);
  wire is_stop   = (bitn == stop_idx);
  wire bit_end   = rx_en & tick16 & busy & (phase == LAST);
  wire complete  = bit_end & is_stop;
  wire start_det = rx_en & tick16 & ~busy & prev & ~rx_s;
  wire [IW-1:0] thr = nine_bit ? IW'((DW + 3) * OS) : IW'((DW + 2) * OS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_line;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0; busy <= 1'b0; armed <= 1'b0; nf_acc <= 1'b0;
      idle_pulse <= 1'b0; phase <= '0; bitn <= '0; smp <= '0;
      shreg <= '0; icnt <= '0;
    end else begin
      idle_pulse <= 1'b0;
      if (!rx_en) begin
        prev <= 1'b0; busy <= 1'b0; armed <= 1'b0; icnt <= '0;
      end else if (tick16) begin
        prev <= rx_s;
        if (start_det) begin
          busy <= 1'b1; phase <= '0; bitn <= '0; nf_acc <= 1'b0;
          armed <= 1'b1; icnt <= '0;
        end else if (busy) begin
          phase <= (phase == LAST) ? '0 : phase + 1'b1;
          if (phase == S0) smp[0] <= rx_s;
          if (phase == S1) smp[1] <= rx_s;
          if (phase == S2) smp[2] <= rx_s;
          if (phase == LAST) begin
            if (disagree) nf_acc <= 1'b1;
            if ((is_start && vote) || is_stop) begin
              busy <= 1'b0;
            end else begin
              bitn <= bitn + 1'b1;
              if (!is_start) shreg <= {vote, shreg[DW:1]};
            end
          end
        end else if (armed) begin
          if (!rx_s) begin
            icnt <= '0;
          end else if (icnt == thr - 1'b1) begin
            idle_pulse <= 1'b1; armed <= 1'b0; icnt <= '0;
          end else begin
            icnt <= icnt + 1'b1;
          end
        end
      end
    end
  end

  always_comb flg_clr = (data_rd && cap_v) ? cap : 5'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg <= '0; cap <= '0; cap_v <= 1'b0; rx_data <= '0; rx_bit8 <= 1'b0;
    end else if (complete) begin
      flg[F_FULL] <= 1'b1;
      flg[F_OVR]  <= flg[F_OVR] | flg[F_FULL];
      flg[F_NSE]  <= flg[F_NSE] | nf_acc | disagree;
      flg[F_FRM]  <= flg[F_FRM] | ~vote;
      cap_v       <= 1'b0;
      rx_data     <= nine_bit ? shreg[DW-1:0] : shreg[DW:1];
      rx_bit8     <= nine_bit & shreg[DW];
    end else begin
      flg <= (flg & ~flg_clr) | (idle_pulse ? 5'b01000 : 5'b0);
      if (stat_rd) begin
        cap <= flg; cap_v <= 1'b1;
      end else if (data_rd) begin
        cap_v <= 1'b0;
      end
    end
  end

  assign rx_full   = flg[F_FULL];
  assign line_idle = flg[F_IDLE];
  assign overrun   = flg[F_OVR];
  assign noise     = flg[F_NSE];
  assign frame_err = flg[F_FRM];
  assign rx_irq    = rie & (rx_full | overrun);
endmodule

// File: rtl/sci_rx_core_checker.sv
module sci_rx_core_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          rie,
  input logic          data_rd,
  input logic [DW-1:0] rx_data,
  input logic          rx_full,
  input logic          overrun,
  input logic          rx_irq
);
  a_r3_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_full));
  a_r4_full_clears_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(data_rd));
  a_r4_ovr_clears_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> $past(data_rd));
  a_r7_rx_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rx_en));
  a_r2_data_with_full: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_full);
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rie);
  a_r8_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (rie && overrun) |-> rx_irq);
endmodule

bind sci_rx_core sci_rx_core_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rie(rie), .data_rd(data_rd),
  .rx_data(rx_data), .rx_full(rx_full), .overrun(overrun), .rx_irq(rx_irq)
);

// File: tb/sci_rx_core_test.sv
module sci_rx_core_test;
  logic clk = 1'b0, rst_n = 1'b0, rx_line = 1'b1, tick16 = 1'b0;
  logic rx_en = 1'b0, nine_bit = 1'b0, rie = 1'b0, stat_rd = 1'b0, data_rd = 1'b0;
  logic [7:0] rx_data;
  logic rx_bit8, rx_full, line_idle, overrun, noise, frame_err, rx_irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  sci_rx_core uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16), .rx_en(rx_en),
    .nine_bit(nine_bit), .rie(rie), .stat_rd(stat_rd), .data_rd(data_rd),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_full(rx_full), .line_idle(line_idle),
    .overrun(overrun), .noise(noise), .frame_err(frame_err), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_tick(input logic v);
    @(negedge clk) rx_line = v;
    repeat (3) @(posedge clk);
    @(negedge clk) tick16 = 1'b1;
    @(negedge clk) tick16 = 1'b0;
  endtask

  task automatic ticks(input logic v, input int n);
    for (int i = 0; i < n; i++) do_tick(v);
  endtask

  task automatic send_bit(input logic v, input logic glitch);
    for (int t = 0; t < 16; t++) do_tick((glitch && t == 8) ? ~v : v);
  endtask

  task automatic send(input logic [8:0] d, input logic stop, input int glitch_bit);
    ticks(1'b1, 2);
    send_bit(1'b0, 1'b0);
    for (int b = 0; b < (nine_bit ? 9 : 8); b++) send_bit(d[b], glitch_bit == b);
    send_bit(stop, 1'b0);
    ticks(1'b1, 2);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_stat();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
  endtask

  task automatic pulse_data();
    @(negedge clk) data_rd = 1'b1;
    @(negedge clk) data_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_all();
    pulse_stat();
    pulse_data();
  endtask

  task automatic t_reset();
    chk("R1 data", rx_data, 0);
    chk("R1 flags", {rx_full, line_idle, overrun, noise, frame_err, rx_bit8}, 0);
    chk("R1 irq", rx_irq, 0);
  endtask

  task automatic t_basic();
    send(9'h0A5, 1'b1, -1);
    chk("R2 data", rx_data, 8'hA5);
    chk("R2 full", rx_full, 1);
    chk("R8 irq on", rx_irq, 1);
    chk("R10 no frame err", frame_err, 0);
    chk("R9 no noise", noise, 0);
  endtask

  task automatic t_nocap();
    pulse_data();
    chk("R5 full kept", rx_full, 1);
    clear_all();
    chk("R4 full cleared", rx_full, 0);
    chk("R8 irq off", rx_irq, 0);
  endtask

  task automatic t_overrun();
    send(9'h011, 1'b1, -1);
    send(9'h022, 1'b1, -1);
    chk("R3 overrun", overrun, 1);
    chk("R3 newer data", rx_data, 8'h22);
    clear_all();
    chk("R4 both cleared", {rx_full, overrun}, 0);
  endtask

  task automatic t_cancel();
    send(9'h033, 1'b1, -1);
    pulse_stat();
    send(9'h044, 1'b1, -1);
    pulse_data();
    chk("R6 full survives", rx_full, 1);
    chk("R6 overrun survives", overrun, 1);
    clear_all();
    chk("R6 later clear", {rx_full, overrun}, 0);
  endtask

  task automatic t_subset();
    send(9'h055, 1'b1, -1);
    pulse_stat();
    ticks(1'b1, 150);
    repeat (3) @(negedge clk);
    chk("R11 not yet idle", line_idle, 0);
    ticks(1'b1, 15);
    repeat (3) @(negedge clk);
    chk("R11 idle set", line_idle, 1);
    pulse_data();
    chk("R4 captured full cleared", rx_full, 0);
    chk("R4 uncaptured idle kept", line_idle, 1);
    clear_all();
    chk("R4 idle cleared", line_idle, 0);
    ticks(1'b1, 200);
    repeat (3) @(negedge clk);
    chk("R11 idle once", line_idle, 0);
  endtask

  task automatic t_noise();
    send(9'h00F, 1'b1, 3);
    chk("R9 voted data", rx_data, 8'h0F);
    chk("R9 noise", noise, 1);
    clear_all();
    chk("R9 noise cleared", noise, 0);
  endtask

  task automatic t_frame();
    send(9'h07E, 1'b0, -1);
    chk("R10 frame err", frame_err, 1);
    clear_all();
    chk("R10 cleared", frame_err, 0);
  endtask

  task automatic t_nine();
    nine_bit = 1'b1;
    send(9'h13C, 1'b1, -1);
    chk("R12 low byte", rx_data, 8'h3C);
    chk("R12 ninth bit", rx_bit8, 1);
    chk("R12 no frame err", frame_err, 0);
    clear_all();
    nine_bit = 1'b0;
  endtask

  task automatic t_disabled();
    rx_en = 1'b0;
    send(9'h099, 1'b1, -1);
    chk("R7 no full", rx_full, 0);
    chk("R7 data held", rx_data, 8'h3C);
    rx_en = 1'b1;
  endtask

  task automatic t_rie();
    rie = 1'b0;
    send(9'h001, 1'b1, -1);
    chk("R8 full with rie off", rx_full, 1);
    chk("R8 irq gated", rx_irq, 0);
    rie = 1'b1;
    @(negedge clk);
    chk("R8 irq enabled", rx_irq, 1);
    clear_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    rx_en = 1'b1;
    rie = 1'b1;
    t_basic();
    t_nocap();
    t_overrun();
    t_cancel();
    t_subset();
    t_noise();
    t_frame();
    t_nine();
    t_disabled();
    t_rie();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule